// File: doc/BRIEF.md
# Unified Data-Space Address Decoder

This block sits between the execution stage of a small 8-bit microcontroller core and everything the core can address as a byte. It has two request ports. The load/store port takes a full linear data address. The port-access port takes a 6-bit I/O port number. The linear space has three regions. The lowest 32 bytes are the general register file. The next 64 bytes are the I/O window. Everything above that is external data memory. A load/store to the I/O window behaves exactly like a port access to the matching port.

The top eight I/O ports are core special registers, held inside the block. These are four extended-address bytes, an extended indirect-jump byte, the two stack-pointer bytes and the status flags. All other I/O ports go to an external byte bus at a fixed base offset plus the port number. Build-time switches say whether each extended-address byte and the upper stack-pointer byte exist. A write to a missing register is dropped. Accesses to registers inside the block are acknowledged in the cycle they are presented. The external bus uses a valid/ready handshake.

Top module: `dspace_decoder`

## Requirements
- R1: A load/store whose address is below 32 reads or writes general register number `addr`. It is acknowledged in the same cycle the request is presented, with `mem_valid` low, and a write is visible from the next cycle.
- R2: A load/store address from 32 to 95 acts as a port access to port `addr - 32`, with identical routing, data and side effects.
- R3: A load/store address of 96 or more raises `mem_valid` with `mem_addr` equal to that address and `mem_we`/`mem_wdata` taken from the request. The request is acknowledged in the cycle `mem_ready` is high, and read data is `mem_rdata`.
- R4: A port access to a port below 0x38 goes to the external bus at address `IO_BASE + port` (default base 32) and is acknowledged by `mem_ready`.
- R5: Ports 0x38, 0x39, 0x3A and 0x3B are extended-address bytes 0 to 3 (the data, X, Y and Z pointer extensions). A write stores the byte in bits 23:16 of that register's 24-bit output `ext_o[k]`, with bits 15:0 zero. A read returns bits 23:16. If the register's enable parameter is 0, the write is dropped and the register reads as zero.
- R6: Port 0x3C is the indirect-jump extension byte. A write is always accepted into bits 23:16 of `jmp_o`, and a read returns that byte.
- R7: A write to port 0x3D replaces `sp_o[7:0]` and leaves `sp_o[15:8]` unchanged.
- R8: A write to port 0x3E replaces `sp_o[15:8]` only when `HAS_SP_HI` is 1. Otherwise the write is dropped and port 0x3E reads zero.
- R9: A write to port 0x3F loads all eight bits of `flags_o` from the data byte. A read returns `flags_o`.
- R10: After reset all special registers and general registers are zero.
- R11: When both request ports are active in one cycle, only the load/store port is served. The port-access request gets no acknowledge and has no effect until the load/store request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_req | input | 1 | Load/store request, held until acknowledged |
| ls_we | input | 1 | Load/store is a write |
| ls_addr | input | AW | Linear data address |
| ls_wdata | input | 8 | Load/store write byte |
| ls_ack | output | 1 | Load/store completes this cycle |
| ls_rdata | output | 8 | Load/store read byte, valid with `ls_ack` |
| io_req | input | 1 | Port-access request, held until acknowledged |
| io_we | input | 1 | Port access is a write |
| io_port | input | 6 | I/O port number |
| io_wdata | input | 8 | Port-access write byte |
| io_ack | output | 1 | Port access completes this cycle |
| io_rdata | output | 8 | Port-access read byte, valid with `io_ack` |
| mem_valid | output | 1 | External bus request |
| mem_we | output | 1 | External bus write |
| mem_addr | output | AW | External bus byte address |
| mem_wdata | output | 8 | External bus write byte |
| mem_ready | input | 1 | External bus completes this cycle |
| mem_rdata | input | 8 | External bus read byte |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 8 | Status flags |
| jmp_o | output | 24 | Indirect-jump extension, byte in 23:16 |
| ext_o | output | 4x24 | Extended-address registers 0 to 3, byte in 23:16 |

## Verification
The assertions assume that a requester holds its request, address, direction and data steady until it sees its acknowledge. They also assume that the external bus keeps `mem_ready` low while it is not ready. The stall check on the bus address depends on both assumptions. The bench drives every request on a falling edge. It keeps the request unchanged through the cycle in which the acknowledge is sampled, and withdraws it only on a later falling edge. A stalled port-access request is held unchanged across the whole time the load/store port wins.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

  typedef enum logic [1:0] {
    TGT_GPR  = 2'd0,
    TGT_SPEC = 2'd1,
    TGT_MEM  = 2'd2
  } tgt_e;

  // order follows the port numbers of the top eight I/O ports
  typedef enum logic [2:0] {
    SR_EXT0  = 3'd0,
    SR_EXT1  = 3'd1,
    SR_EXT2  = 3'd2,
    SR_EXT3  = 3'd3,
    SR_JMP   = 3'd4,
    SR_SPL   = 3'd5,
    SR_SPH   = 3'd6,
    SR_FLAGS = 3'd7
  } sreg_e;

endpackage

// File: rtl/dspace_route.sv
module dspace_route
  import dspace_pkg::*;
#(
  parameter int AW      = 16,
  parameter int GPR_N   = 32,
  parameter int IO_N    = 64,
  parameter int IO_BASE = 32,
  localparam int GW     = $clog2(GPR_N),
  localparam int IOW    = $clog2(IO_N),
  localparam int SPEC_FIRST = IO_N - 8
) (
  input  logic           ls_req,
  input  logic           ls_we,
  input  logic [AW-1:0]  ls_addr,
  input  logic [7:0]     ls_wdata,
  input  logic           io_req,
  input  logic           io_we,
  input  logic [IOW-1:0] io_port,
  input  logic [7:0]     io_wdata,
  output logic           act,
  output logic           act_we,
  output logic [7:0]     act_wdata,
  output tgt_e           tgt,
  output logic [GW-1:0]  gpr_idx,
  output sreg_e          sr_sel,
  output logic [AW-1:0]  fwd_addr
);

  logic           ls_in_gpr;
  logic           ls_in_io;
  logic           via_io;
  logic [IOW-1:0] port;

  always_comb begin
    ls_in_gpr = ls_addr < AW'(GPR_N);
    ls_in_io  = !ls_in_gpr && (ls_addr < AW'(GPR_N + IO_N));
    // load/store always wins; the port-access side only drives when it is alone
    port      = ls_req ? (ls_addr[IOW-1:0] - IOW'(GPR_N)) : io_port;
    via_io    = ls_req ? ls_in_io : 1'b1;
    act       = ls_req | io_req;
    act_we    = ls_req ? ls_we : io_we;
    act_wdata = ls_req ? ls_wdata : io_wdata;
    gpr_idx   = ls_addr[GW-1:0];
    sr_sel    = sreg_e'(port[2:0] - 3'(SPEC_FIRST));

    if (ls_req && ls_in_gpr)
      tgt = TGT_GPR;
    else if (via_io && (port >= IOW'(SPEC_FIRST)))
      tgt = TGT_SPEC;
    else
      tgt = TGT_MEM;

    fwd_addr = via_io ? (AW'(IO_BASE) + {{(AW-IOW){1'b0}}, port}) : ls_addr;
  end

endmodule

// File: rtl/dspace_gpr.sv
module dspace_gpr #(
  parameter int GPR_N = 32,
  localparam int GW   = $clog2(GPR_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [GW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] regs [GPR_N];

  for (genvar g = 0; g < GPR_N; g++) begin : g_reg
    logic [7:0] nxt;
    logic       hit;

    always_comb begin
      hit = wr_en && (idx == GW'(g));
      nxt = hit ? wdata : regs[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= 8'h00;
      else if (hit) regs[g] <= nxt;
    end
  end

  assign rdata = regs[idx];

  p_gpr_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(idx)] == $past(wdata));

endmodule

// File: rtl/dspace_spec.sv
module dspace_spec
  import dspace_pkg::*;
#(
  parameter bit HAS_EXT0  = 1'b1,
  parameter bit HAS_EXT1  = 1'b1,
  parameter bit HAS_EXT2  = 1'b1,
  parameter bit HAS_EXT3  = 1'b1,
  parameter bit HAS_SP_HI = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  sreg_e            sel,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [15:0]      sp_o,
  output logic [7:0]       flags_o,
  output logic [23:0]      jmp_o,
  output logic [3:0][23:0] ext_o
);

  localparam bit [3:0] EXT_EN = {HAS_EXT3, HAS_EXT2, HAS_EXT1, HAS_EXT0};

  // extended-address bytes, each only present when enabled
  for (genvar k = 0; k < 4; k++) begin : g_ext
    if (EXT_EN[k]) begin : g_on
      logic [7:0] q;
      logic [7:0] d;
      logic       en;
      always_comb begin
        en = wr_en && (sel == sreg_e'(3'(k)));
        d  = en ? wdata : q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 8'h00;
        else if (en) q <= d;
      end
      assign ext_o[k] = {q, 16'h0000};
    end else begin : g_off
      assign ext_o[k] = 24'h000000;
    end
  end

  // indirect-jump extension, always present
  logic [7:0] jmp_q, jmp_d;
  logic       jmp_en;
  always_comb begin
    jmp_en = wr_en && (sel == SR_JMP);
    jmp_d  = jmp_en ? wdata : jmp_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) jmp_q <= 8'h00;
    else if (jmp_en) jmp_q <= jmp_d;
  end
  assign jmp_o = {jmp_q, 16'h0000};

  // stack pointer low byte
  logic [7:0] spl_q, spl_d;
  logic       spl_en;
  always_comb begin
    spl_en = wr_en && (sel == SR_SPL);
    spl_d  = spl_en ? wdata : spl_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spl_q <= 8'h00;
    else if (spl_en) spl_q <= spl_d;
  end

  // stack pointer high byte
  logic [7:0] sph_val;
  if (HAS_SP_HI) begin : g_sph
    logic [7:0] q, d;
    logic       en;
    always_comb begin
      en = wr_en && (sel == SR_SPH);
      d  = en ? wdata : q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 8'h00;
      else if (en) q <= d;
    end
    assign sph_val = q;
  end else begin : g_no_sph
    assign sph_val = 8'h00;
  end
  assign sp_o = {sph_val, spl_q};

  // status flags
  logic [7:0] flg_q, flg_d;
  logic       flg_en;
  always_comb begin
    flg_en = wr_en && (sel == SR_FLAGS);
    flg_d  = flg_en ? wdata : flg_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= 8'h00;
    else if (flg_en) flg_q <= flg_d;
  end
  assign flags_o = flg_q;

  always_comb begin
    case (sel)
      SR_EXT0:  rdata = ext_o[0][23:16];
      SR_EXT1:  rdata = ext_o[1][23:16];
      SR_EXT2:  rdata = ext_o[2][23:16];
      SR_EXT3:  rdata = ext_o[3][23:16];
      SR_JMP:   rdata = jmp_q;
      SR_SPL:   rdata = spl_q;
      SR_SPH:   rdata = sph_val;
      default:  rdata = flg_q;
    endcase
  end

  p_spl_keeps_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SR_SPL) |=> (sp_o[7:0] == $past(wdata)) &&
                                 (sp_o[15:8] == $past(sp_o[15:8])));

  p_sph_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SR_SPH) |=>
      sp_o[15:8] == (HAS_SP_HI ? $past(wdata) : $past(sp_o[15:8])));

  p_flags_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SR_FLAGS) |=> flags_o == $past(wdata));

  p_ext_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_o[0][15:0] == 16'h0) && (ext_o[3][15:0] == 16'h0) && (jmp_o[15:0] == 16'h0));

endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
  import dspace_pkg::*;
#(
  parameter int AW        = 16,
  parameter int GPR_N     = 32,
  parameter int IO_N      = 64,
  parameter int IO_BASE   = 32,
  parameter bit HAS_EXT0  = 1'b1,
  parameter bit HAS_EXT1  = 1'b1,
  parameter bit HAS_EXT2  = 1'b1,
  parameter bit HAS_EXT3  = 1'b1,
  parameter bit HAS_SP_HI = 1'b1,
  localparam int GW       = $clog2(GPR_N),
  localparam int IOW      = $clog2(IO_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ls_req,
  input  logic             ls_we,
  input  logic [AW-1:0]    ls_addr,
  input  logic [7:0]       ls_wdata,
  output logic             ls_ack,
  output logic [7:0]       ls_rdata,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IOW-1:0]   io_port,
  input  logic [7:0]       io_wdata,
  output logic             io_ack,
  output logic [7:0]       io_rdata,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ready,
  input  logic [7:0]       mem_rdata,
  output logic [15:0]      sp_o,
  output logic [7:0]       flags_o,
  output logic [23:0]      jmp_o,
  output logic [3:0][23:0] ext_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic          act, act_we;
  logic [7:0]    act_wdata;
  tgt_e          tgt;
  logic [GW-1:0] gpr_idx;
  sreg_e         sr_sel;
  logic [AW-1:0] fwd_addr;

  dspace_route #(
    .AW(AW), .GPR_N(GPR_N), .IO_N(IO_N), .IO_BASE(IO_BASE)
  ) u_route (
    .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr), .ls_wdata(ls_wdata),
    .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_wdata(io_wdata),
    .act(act), .act_we(act_we), .act_wdata(act_wdata), .tgt(tgt),
    .gpr_idx(gpr_idx), .sr_sel(sr_sel), .fwd_addr(fwd_addr)
  );

  logic       gpr_wr, sr_wr, done;
  logic [7:0] gpr_rd, sr_rd, rd_mux;

  always_comb begin
    gpr_wr = act && act_we && (tgt == TGT_GPR);
    sr_wr  = act && act_we && (tgt == TGT_SPEC);
    done   = act && ((tgt != TGT_MEM) || mem_ready);
    case (tgt)
      TGT_GPR:  rd_mux = gpr_rd;
      TGT_SPEC: rd_mux = sr_rd;
      default:  rd_mux = mem_rdata;
    endcase
  end

  dspace_gpr #(.GPR_N(GPR_N)) u_gpr (
    .clk(clk), .rst_n(rst_sync), .wr_en(gpr_wr), .idx(gpr_idx),
    .wdata(act_wdata), .rdata(gpr_rd)
  );

  dspace_spec #(
    .HAS_EXT0(HAS_EXT0), .HAS_EXT1(HAS_EXT1), .HAS_EXT2(HAS_EXT2),
    .HAS_EXT3(HAS_EXT3), .HAS_SP_HI(HAS_SP_HI)
  ) u_spec (
    .clk(clk), .rst_n(rst_sync), .wr_en(sr_wr), .sel(sr_sel),
    .wdata(act_wdata), .rdata(sr_rd), .sp_o(sp_o), .flags_o(flags_o),
    .jmp_o(jmp_o), .ext_o(ext_o)
  );

  assign ls_ack    = ls_req && done;
  assign io_ack    = !ls_req && io_req && done;
  assign ls_rdata  = rd_mux;
  assign io_rdata  = rd_mux;
  assign mem_valid = act && (tgt == TGT_MEM);
  assign mem_we    = act_we;
  assign mem_addr  = fwd_addr;
  assign mem_wdata = act_wdata;

  p_ls_wins_r11: assert property (@(posedge clk) disable iff (!rst_sync)
    (ls_req && io_req) |-> !io_ack);

  p_one_ack_r11: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0({ls_ack, io_ack}));

  p_gpr_local_r1: assert property (@(posedge clk) disable iff (!rst_sync)
    (ls_req && ls_addr < AW'(GPR_N)) |-> (ls_ack && !mem_valid));

  p_high_to_mem_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    (ls_req && ls_addr >= AW'(GPR_N + IO_N)) |-> (mem_valid && mem_addr == ls_addr));

  p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

endmodule

// File: tb/dspace_decoder_test.sv
module dspace_decoder_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        ls_req, ls_we, io_req, io_we, mem_rdy;
  logic [15:0] ls_addr;
  logic [7:0]  ls_wdata, io_wdata;
  logic [5:0]  io_port;

  logic        ls_ack_a, io_ack_a, mv_a, mwe_a, ls_ack_b, io_ack_b, mv_b, mwe_b;
  logic [7:0]  ls_rd_a, io_rd_a, mwd_a, ls_rd_b, io_rd_b, mwd_b, flg_a, flg_b;
  logic [15:0] ma_a, ma_b, sp_a, sp_b;
  logic [23:0] jmp_a, jmp_b;
  logic [3:0][23:0] ext_a, ext_b;
  logic [7:0]  mrd_a, mrd_b;

  function automatic logic [7:0] fm(input logic [15:0] x);
    return x[7:0] ^ x[15:8] ^ 8'h3C;
  endfunction

  assign mrd_a = fm(ma_a);
  assign mrd_b = fm(ma_b);

  // A: ext 0 and 2 present, two-byte stack pointer
  dspace_decoder #(.HAS_EXT0(1'b1), .HAS_EXT1(1'b0), .HAS_EXT2(1'b1),
                   .HAS_EXT3(1'b0), .HAS_SP_HI(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr),
    .ls_wdata(ls_wdata), .ls_ack(ls_ack_a), .ls_rdata(ls_rd_a), .io_req(io_req),
    .io_we(io_we), .io_port(io_port), .io_wdata(io_wdata), .io_ack(io_ack_a),
    .io_rdata(io_rd_a), .mem_valid(mv_a), .mem_we(mwe_a), .mem_addr(ma_a),
    .mem_wdata(mwd_a), .mem_ready(mem_rdy), .mem_rdata(mrd_a), .sp_o(sp_a),
    .flags_o(flg_a), .jmp_o(jmp_a), .ext_o(ext_a));

  // B: ext 1 and 3 present, one-byte stack pointer
  dspace_decoder #(.HAS_EXT0(1'b0), .HAS_EXT1(1'b1), .HAS_EXT2(1'b0),
                   .HAS_EXT3(1'b1), .HAS_SP_HI(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr),
    .ls_wdata(ls_wdata), .ls_ack(ls_ack_b), .ls_rdata(ls_rd_b), .io_req(io_req),
    .io_we(io_we), .io_port(io_port), .io_wdata(io_wdata), .io_ack(io_ack_b),
    .io_rdata(io_rd_b), .mem_valid(mv_b), .mem_we(mwe_b), .mem_addr(ma_b),
    .mem_wdata(mwd_b), .mem_ready(mem_rdy), .mem_rdata(mrd_b), .sp_o(sp_b),
    .flags_o(flg_b), .jmp_o(jmp_b), .ext_o(ext_b));

  int vec = 0;
  int bad = 0;
  localparam logic [3:0] EN_A = 4'b0101;
  localparam logic [3:0] EN_B = 4'b1010;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // one access on both instances; the expected target decides the phases
  task automatic acc(input bit use_io, input bit we, input logic [15:0] a,
                     input logic [7:0] d, input bit to_mem, input logic [15:0] xaddr,
                     input string tag, output logic [7:0] rd_a, output logic [7:0] rd_b);
    @(negedge clk);
    if (use_io) begin
      io_req = 1'b1; io_we = we; io_port = a[5:0]; io_wdata = d;
    end else begin
      ls_req = 1'b1; ls_we = we; ls_addr = a; ls_wdata = d;
    end
    mem_rdy = 1'b0;
    #1;
    if (!to_mem) begin
      chk({tag, " ack"}, 32'(use_io ? io_ack_a : ls_ack_a), 32'd1);
      chk({tag, " no bus"}, 32'(mv_a | mv_b), 32'd0);
      rd_a = use_io ? io_rd_a : ls_rd_a;
      rd_b = use_io ? io_rd_b : ls_rd_b;
    end else begin
      chk({tag, " wait"}, 32'(use_io ? io_ack_a : ls_ack_a), 32'd0);
      chk({tag, " valid"}, 32'(mv_a), 32'd1);
      chk({tag, " addr"}, 32'(ma_a), 32'(xaddr));
      chk({tag, " addr b"}, 32'(ma_b), 32'(xaddr));
      chk({tag, " dir"}, 32'(mwe_a), 32'(we));
      if (we) chk({tag, " wdata"}, 32'(mwd_a), 32'(d));
      @(negedge clk);
      mem_rdy = 1'b1;
      #1;
      chk({tag, " done"}, 32'(use_io ? io_ack_a : ls_ack_a), 32'd1);
      rd_a = use_io ? io_rd_a : ls_rd_a;
      rd_b = use_io ? io_rd_b : ls_rd_b;
    end
    @(negedge clk);
    ls_req = 1'b0; io_req = 1'b0; ls_we = 1'b0; io_we = 1'b0; mem_rdy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; vec++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [7:0] ra, rb;
    logic [7:0] ea [4];
    logic [7:0] eb [4];
    rst_n = 1'b0; ls_req = 1'b0; ls_we = 1'b0; ls_addr = '0; ls_wdata = '0;
    io_req = 1'b0; io_we = 1'b0; io_port = '0; io_wdata = '0; mem_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset values at the outputs and through reads
    chk("R10 sp", 32'(sp_a), 32'd0);
    chk("R10 flags", 32'(flg_a), 32'd0);
    chk("R10 jmp", 32'(jmp_a), 32'd0);
    chk("R10 ext", 32'(ext_a[0] | ext_a[2] | ext_b[1] | ext_b[3]), 32'd0);
    for (int p = 56; p < 64; p++) begin
      acc(1'b1, 1'b0, 16'(p), 8'h00, 1'b0, 16'h0, "R10 special read", ra, rb);
      chk("R10 special a", 32'(ra), 32'd0);
      chk("R10 special b", 32'(rb), 32'd0);
    end
    acc(1'b0, 1'b0, 16'd7, 8'h00, 1'b0, 16'h0, "R10 gpr read", ra, rb);
    chk("R10 gpr", 32'(ra), 32'd0);

    // R1: full register-file sweep
    for (int i = 0; i < 32; i++)
      acc(1'b0, 1'b1, 16'(i), pat(i), 1'b0, 16'h0, "R1 write", ra, rb);
    for (int i = 0; i < 32; i++) begin
      acc(1'b0, 1'b0, 16'(i), 8'h00, 1'b0, 16'h0, "R1 read", ra, rb);
      chk("R1 data a", 32'(ra), 32'(pat(i)));
      chk("R1 data b", 32'(rb), 32'(pat(i)));
    end

    // R4: ordinary ports through the port-access side
    for (int p = 0; p < 56; p++) begin
      acc(1'b1, 1'b0, 16'(p), 8'h00, 1'b1, 16'(32 + p), "R4 read", ra, rb);
      chk("R4 rdata", 32'(ra), 32'(fm(16'(32 + p))));
      acc(1'b1, 1'b1, 16'(p), 8'(p) ^ 8'hC3, 1'b1, 16'(32 + p), "R4 write", ra, rb);
    end

    // R2: same ports through the linear window
    for (int p = 0; p < 56; p++) begin
      acc(1'b0, 1'b0, 16'(32 + p), 8'h00, 1'b1, 16'(32 + p), "R2 read", ra, rb);
      chk("R2 rdata", 32'(ra), 32'(fm(16'(32 + p))));
    end

    // R3: linear addresses beyond the I/O window
    begin
      logic [15:0] hi [5];
      hi = '{16'd96, 16'd97, 16'h00FF, 16'h1234, 16'hFFFF};
      foreach (hi[j]) begin
        acc(1'b0, 1'b0, hi[j], 8'h00, 1'b1, hi[j], "R3 read", ra, rb);
        chk("R3 rdata", 32'(ra), 32'(fm(hi[j])));
        acc(1'b0, 1'b1, hi[j], hi[j][7:0] + 8'h11, 1'b1, hi[j], "R3 write", ra, rb);
      end
    end

    // R5: extended-address bytes with feature gating (R2 path for reads)
    for (int k = 0; k < 4; k++) begin
      ea[k] = EN_A[k] ? 8'(8'h90 + k) : 8'h00;
      eb[k] = EN_B[k] ? 8'(8'h90 + k) : 8'h00;
      acc(1'b1, 1'b1, 16'(56 + k), 8'(8'h90 + k), 1'b0, 16'h0, "R5 write", ra, rb);
    end
    for (int k = 0; k < 4; k++) begin
      acc(1'b1, 1'b0, 16'(56 + k), 8'h00, 1'b0, 16'h0, "R5 read", ra, rb);
      chk("R5 read a", 32'(ra), 32'(ea[k]));
      chk("R5 read b", 32'(rb), 32'(eb[k]));
      chk("R5 out a", 32'(ext_a[k]), 32'({ea[k], 16'h0}));
      chk("R5 out b", 32'(ext_b[k]), 32'({eb[k], 16'h0}));
      acc(1'b0, 1'b0, 16'(88 + k), 8'h00, 1'b0, 16'h0, "R2 ext read", ra, rb);
      chk("R2 ext a", 32'(ra), 32'(ea[k]));
    end
    acc(1'b0, 1'b1, 16'd91, 8'h6B, 1'b0, 16'h0, "R2 ext write", ra, rb);
    chk("R2 R5 ext3 b", 32'(ext_b[3]), 32'h6B0000);
    chk("R5 ext3 a off", 32'(ext_a[3]), 32'h0);

    // R6: jump extension always writable
    acc(1'b0, 1'b1, 16'd92, 8'h7E, 1'b0, 16'h0, "R6 write", ra, rb);
    chk("R6 out a", 32'(jmp_a), 32'h7E0000);
    chk("R6 out b", 32'(jmp_b), 32'h7E0000);
    acc(1'b1, 1'b0, 16'h3C, 8'h00, 1'b0, 16'h0, "R6 read", ra, rb);
    chk("R6 read", 32'(rb), 32'h7E);

    // R7 / R8: stack pointer halves
    acc(1'b1, 1'b1, 16'h3D, 8'h34, 1'b0, 16'h0, "R7 low", ra, rb);
    acc(1'b1, 1'b1, 16'h3E, 8'h12, 1'b0, 16'h0, "R8 high", ra, rb);
    chk("R8 sp a", 32'(sp_a), 32'h1234);
    chk("R8 sp b dropped", 32'(sp_b), 32'h0034);
    acc(1'b1, 1'b0, 16'h3E, 8'h00, 1'b0, 16'h0, "R8 read", ra, rb);
    chk("R8 read a", 32'(ra), 32'h12);
    chk("R8 read b", 32'(rb), 32'h00);
    acc(1'b0, 1'b1, 16'd93, 8'h56, 1'b0, 16'h0, "R7 low again", ra, rb);
    chk("R7 sp a", 32'(sp_a), 32'h1256);
    chk("R7 sp b", 32'(sp_b), 32'h0056);

    // R9: every flag byte value
    for (int v = 0; v < 256; v++) begin
      acc(1'b0, 1'b1, 16'd95, 8'(v), 1'b0, 16'h0, "R9 write", ra, rb);
      chk("R9 out", 32'(flg_a), 32'(v));
      acc(1'b1, 1'b0, 16'h3F, 8'h00, 1'b0, 16'h0, "R9 read", ra, rb);
      chk("R9 read", 32'(rb), 32'(v));
    end

    // R11: simultaneous requests, load/store wins
    @(negedge clk);
    ls_req = 1'b1; ls_we = 1'b0; ls_addr = 16'd5;
    io_req = 1'b1; io_we = 1'b1; io_port = 6'h3F; io_wdata = 8'hA5;
    #1;
    chk("R11 ls ack", 32'(ls_ack_a), 32'd1);
    chk("R11 io stalled", 32'(io_ack_a), 32'd0);
    chk("R11 ls data", 32'(ls_rd_a), 32'(pat(5)));
    @(negedge clk); #1;
    chk("R11 io still stalled", 32'(io_ack_a | io_ack_b), 32'd0);
    chk("R11 flags untouched", 32'(flg_a), 32'hFF);
    @(negedge clk);
    ls_req = 1'b0;
    #1;
    chk("R11 io served", 32'(io_ack_a), 32'd1);
    @(negedge clk);
    io_req = 1'b0; io_we = 1'b0;
    #1;
    chk("R11 flags written", 32'(flg_a), 32'hA5);

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule